// File: doc/BRIEF.md
# Adaptive Black Stretch with Windowed Dark-Level Detector

This block darkens the shadows of a video picture whose darkest content sits above the black clamp level, so that a washed-out dark scene recovers depth. Each pixel arrives with its luminance, its R, G and B samples, its screen coordinates and its valid and sync flags. A detector tracks the smallest luminance seen inside a programmable rectangle of the screen. Borders such as letterbox bars can therefore be left out of the measurement.

At the frame-end pulse the minimum is latched. For the whole of the following frame, the height of that latched value above the clamp level sets a stretch offset, capped by a programmable ceiling. Pixels darker than a fixed threshold are pulled down by a share of that offset. The share shrinks linearly to zero at the threshold. One common correction is taken from all three colour samples, and no result is pushed below the clamp level.

Top module: `black_stretch`

## Requirements
- R1: With `stretch_en` low at the input cycle, the R, G and B outputs equal the inputs of that pixel unchanged.
- R2: The detector considers only cycles with `pix_valid` high and `h_pos` in `win_left..win_right` and `v_pos` in `win_top..win_bottom`, both inclusive. It keeps the minimum `luma_in` of those cycles. Any other cycle has no effect on `dark_level`.
- R3: On a cycle with `frame_end` high, `dark_level` takes the minimum over the frame, including a qualifying pixel in that same cycle. The running minimum then restarts from all-ones. `dark_level` holds between pulses and is 0 after reset.
- R4: The stretch offset is `min(dark_level - black_clamp, stretch_cap)` when `dark_level > black_clamp`, otherwise 0. It uses the value of `dark_level` before any update in the pixel's own cycle.
- R5: With threshold T = 2^TH_LOG2 (128 by default), the correction is `floor(offset * (T - luma_in) / T)` when `luma_in < T`, and 0 otherwise.
- R6: Each channel c becomes `c - corr` if `c > black_clamp + corr`. If instead `c < black_clamp`, it stays `c`. Otherwise it becomes `black_clamp`. The `black_clamp` used is the one sampled with the pixel.
- R7: `valid_out`, `hsync_out`, `vsync_out` and the colour outputs appear exactly 2 clocks after the pixel's input cycle.
- R8: During and right after reset, all outputs and `dark_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| stretch_en | input | 1 | Enables the stretch |
| black_clamp | input | 8 | Clamp level and lower bound of the result |
| stretch_cap | input | 8 | Ceiling of the stretch offset |
| win_left | input | POS_W | First column of the detection window |
| win_right | input | POS_W | Last column of the detection window |
| win_top | input | POS_W | First line of the detection window |
| win_bottom | input | POS_W | Last line of the detection window |
| h_pos | input | POS_W | Column of the current pixel |
| v_pos | input | POS_W | Line of the current pixel |
| frame_end | input | 1 | One-cycle pulse closing the frame |
| pix_valid | input | 1 | Pixel qualifier |
| hsync_in | input | 1 | Line sync |
| vsync_in | input | 1 | Frame sync |
| luma_in | input | 8 | Luminance of the pixel |
| r_in | input | 8 | Red sample |
| g_in | input | 8 | Green sample |
| b_in | input | 8 | Blue sample |
| r_out | output | 8 | Stretched red |
| g_out | output | 8 | Stretched green |
| b_out | output | 8 | Stretched blue |
| valid_out | output | 1 | Delayed qualifier |
| hsync_out | output | 1 | Delayed line sync |
| vsync_out | output | 1 | Delayed frame sync |
| dark_level | output | 8 | Latched peak-dark value in force for the current frame |

## Verification
Latching the frame's minimum and applying the previous minimum to a pixel can fall in the same cycle. The frame-end pulse also collides with the frame's own darkest in-window pixel. The bench provokes both by placing a forced minimum on the last pixel of a frame whose window covers it, with `frame_end` high in that cycle. The result is judged in two ways. `dark_level` must then show that last value. The pixel's own output must still be computed with the offset of the earlier frame. The next frame's pixels must use the new offset.

// File: rtl/bs_pkg.sv
package bs_pkg;

    localparam int PIX_W = 8;
    localparam int NCH   = 3;

    typedef logic [PIX_W-1:0] chan_t;
    typedef chan_t [NCH-1:0]  rgb_t;

    localparam chan_t PIX_MAX = '1;

    typedef struct packed {
        logic  valid;
        logic  hs;
        logic  vs;
        chan_t clamp;
        chan_t corr;
        rgb_t  rgb;
    } s1_t;

    typedef struct packed {
        logic  valid;
        logic  hs;
        logic  vs;
        rgb_t  rgb;
    } px_t;

    // Offset from the latched dark level, capped.
    function automatic chan_t stretch_offset(chan_t peak, chan_t clamp, chan_t cap);
        chan_t d;
        if (peak <= clamp) return '0;
        d = peak - clamp;
        return (d > cap) ? cap : d;
    endfunction

    // Linear taper: full offset at black, zero at the threshold 2^thl.
    function automatic chan_t taper_corr(chan_t off, chan_t luma, int unsigned thl);
        logic [PIX_W:0]   th;
        logic [PIX_W:0]   span;
        logic [2*PIX_W:0] prod;
        th = (PIX_W+1)'(1) << thl;
        if ({1'b0, luma} >= th) return '0;
        span = th - {1'b0, luma};
        prod = {(PIX_W+1)'(0), off} * {PIX_W'(0), span};
        prod = prod >> thl;
        return prod[PIX_W-1:0];
    endfunction

    // Subtract the correction, never pushing below the clamp level.
    function automatic chan_t limit_chan(chan_t ch, chan_t corr, chan_t clamp);
        logic [PIX_W:0] floor_sum;
        floor_sum = {1'b0, clamp} + {1'b0, corr};
        if ({1'b0, ch} > floor_sum) return ch - corr;
        if (ch < clamp) return ch;
        return clamp;
    endfunction

endpackage

// File: rtl/bs_peak_detect.sv
module bs_peak_detect
    import bs_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [POS_W-1:0] h_pos,
    input  logic [POS_W-1:0] v_pos,
    input  logic [POS_W-1:0] win_left,
    input  logic [POS_W-1:0] win_right,
    input  logic [POS_W-1:0] win_top,
    input  logic [POS_W-1:0] win_bottom,
    input  chan_t            luma,
    input  logic             frame_end,
    output chan_t            dark_level
);
    logic  in_win;
    chan_t run_min;
    chan_t cand;

    always_comb begin
        in_win = pix_valid
              && (h_pos >= win_left) && (h_pos <= win_right)
              && (v_pos >= win_top)  && (v_pos <= win_bottom);
        cand   = (in_win && (luma < run_min)) ? luma : run_min;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_min    <= PIX_MAX;
            dark_level <= '0;
        end else if (frame_end) begin
            dark_level <= cand;
            run_min    <= PIX_MAX;
        end else begin
            run_min    <= cand;
        end
    end
endmodule

// File: rtl/bs_corr_stage.sv
module bs_corr_stage
    import bs_pkg::*;
#(
    parameter int TH_LOG2 = 7
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  pix_valid,
    input  logic  hs,
    input  logic  vs,
    input  chan_t luma,
    input  rgb_t  rgb,
    input  chan_t peak,
    input  chan_t clamp,
    input  chan_t cap,
    output s1_t   s1
);
    chan_t off;
    chan_t corr;

    always_comb begin
        off  = stretch_offset(peak, clamp, cap);
        corr = en ? taper_corr(off, luma, TH_LOG2) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= pix_valid;
            s1.hs    <= hs;
            s1.vs    <= vs;
            s1.clamp <= clamp;
            s1.corr  <= corr;
            s1.rgb   <= rgb;
        end
    end
endmodule

// File: rtl/bs_out_stage.sv
module bs_out_stage
    import bs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1,
    output px_t  px
);
    rgb_t lim;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign lim[c] = limit_chan(s1.rgb[c], s1.corr, s1.clamp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            px <= '0;
        end else begin
            px.valid <= s1.valid;
            px.hs    <= s1.hs;
            px.vs    <= s1.vs;
            px.rgb   <= lim;
        end
    end
endmodule

// File: rtl/black_stretch.sv
module black_stretch
    import bs_pkg::*;
#(
    parameter int POS_W   = 10,
    parameter int TH_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stretch_en,
    input  logic [7:0]       black_clamp,
    input  logic [7:0]       stretch_cap,
    input  logic [POS_W-1:0] win_left,
    input  logic [POS_W-1:0] win_right,
    input  logic [POS_W-1:0] win_top,
    input  logic [POS_W-1:0] win_bottom,
    input  logic [POS_W-1:0] h_pos,
    input  logic [POS_W-1:0] v_pos,
    input  logic             frame_end,
    input  logic             pix_valid,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [7:0]       luma_in,
    input  logic [7:0]       r_in,
    input  logic [7:0]       g_in,
    input  logic [7:0]       b_in,
    output logic [7:0]       r_out,
    output logic [7:0]       g_out,
    output logic [7:0]       b_out,
    output logic             valid_out,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic [7:0]       dark_level
);
    localparam int CH_R = 2;
    localparam int CH_G = 1;
    localparam int CH_B = 0;

    rgb_t  rgb_in;
    chan_t peak;
    s1_t   s1;
    px_t   px;

    assign rgb_in[CH_R] = r_in;
    assign rgb_in[CH_G] = g_in;
    assign rgb_in[CH_B] = b_in;

    bs_peak_detect #(.POS_W(POS_W)) u_det (
        .clk        (clk),
        .rst        (rst),
        .pix_valid  (pix_valid),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .win_left   (win_left),
        .win_right  (win_right),
        .win_top    (win_top),
        .win_bottom (win_bottom),
        .luma       (luma_in),
        .frame_end  (frame_end),
        .dark_level (peak)
    );

    bs_corr_stage #(.TH_LOG2(TH_LOG2)) u_corr (
        .clk       (clk),
        .rst       (rst),
        .en        (stretch_en),
        .pix_valid (pix_valid),
        .hs        (hsync_in),
        .vs        (vsync_in),
        .luma      (luma_in),
        .rgb       (rgb_in),
        .peak      (peak),
        .clamp     (black_clamp),
        .cap       (stretch_cap),
        .s1        (s1)
    );

    bs_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .s1  (s1),
        .px  (px)
    );

    assign r_out      = px.rgb[CH_R];
    assign g_out      = px.rgb[CH_G];
    assign b_out      = px.rgb[CH_B];
    assign valid_out  = px.valid;
    assign hsync_out  = px.hs;
    assign vsync_out  = px.vs;
    assign dark_level = peak;
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
    parameter int TH_LOG2 = 7
) (
    input logic       clk,
    input logic       rst,
    input logic       stretch_en,
    input logic [7:0] black_clamp,
    input logic       frame_end,
    input logic       pix_valid,
    input logic       hsync_in,
    input logic       vsync_in,
    input logic [7:0] luma_in,
    input logic [7:0] r_in,
    input logic [7:0] g_in,
    input logic [7:0] b_in,
    input logic [7:0] r_out,
    input logic [7:0] g_out,
    input logic [7:0] b_out,
    input logic       valid_out,
    input logic       hsync_out,
    input logic       vsync_out,
    input logic [7:0] dark_level
);
    localparam int TH = 1 << TH_LOG2;

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2) |-> (valid_out == $past(pix_valid, 2)
                           && hsync_out == $past(hsync_in, 2)
                           && vsync_out == $past(vsync_in, 2)));

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $past(!stretch_en, 2)) |->
            (r_out == $past(r_in, 2) && g_out == $past(g_in, 2) && b_out == $past(b_in, 2)));

    p_bright_untouched_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $past(32'(luma_in) >= TH, 2)) |->
            (r_out == $past(r_in, 2) && g_out == $past(g_in, 2) && b_out == $past(b_in, 2)));

    p_never_brighter_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2) |->
            (r_out <= $past(r_in, 2) && g_out <= $past(g_in, 2) && b_out <= $past(b_in, 2)));

    p_clamp_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $past(r_in, 2) >= $past(black_clamp, 2)) |->
            (r_out >= $past(black_clamp, 2)));

    p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(dark_level));
endmodule

bind black_stretch bs_checker #(.TH_LOG2(TH_LOG2)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stretch_en  (stretch_en),
    .black_clamp (black_clamp),
    .frame_end   (frame_end),
    .pix_valid   (pix_valid),
    .hsync_in    (hsync_in),
    .vsync_in    (vsync_in),
    .luma_in     (luma_in),
    .r_in        (r_in),
    .g_in        (g_in),
    .b_in        (b_in),
    .r_out       (r_out),
    .g_out       (g_out),
    .b_out       (b_out),
    .valid_out   (valid_out),
    .hsync_out   (hsync_out),
    .vsync_out   (vsync_out),
    .dark_level  (dark_level)
);

// File: tb/black_stretch_test.sv
module black_stretch_test;
    localparam int POS_W = 10;
    localparam int W     = 16;
    localparam int H     = 8;
    localparam int TH    = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             stretch_en = 1'b0;
    logic [7:0]       black_clamp = '0, stretch_cap = '0;
    logic [POS_W-1:0] win_left = '0, win_right = '0, win_top = '0, win_bottom = '0;
    logic [POS_W-1:0] h_pos = '0, v_pos = '0;
    logic             frame_end = 1'b0, pix_valid = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
    logic [7:0]       luma_in = '0, r_in = '0, g_in = '0, b_in = '0;
    logic [7:0]       r_out, g_out, b_out, dark_level;
    logic             valid_out, hsync_out, vsync_out;

    black_stretch #(.POS_W(POS_W), .TH_LOG2(7)) uut (.*);

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state
    int m_run  = 255;
    int m_peak = 0;
    int ev[2], eh[2], evs[2], er[2], eg[2], eb[2];
    string et[2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_chan(int ch, int corr, int clamp);
        if (ch > clamp + corr) return ch - corr;
        if (ch < clamp) return ch;
        return clamp;
    endfunction

    // One pixel cycle: check outputs due now, then drive the next input.
    task automatic step(input bit v, input int x, input int y, input bit fe,
                        input int lu, input int r, input int g, input int b);
        int off, corr;
        bit inwin;
        @(negedge clk);
        check(valid_out == ev[1] && hsync_out == eh[1] && vsync_out == evs[1],
              "R7", {valid_out, hsync_out, vsync_out}, (ev[1]*4) + (eh[1]*2) + evs[1]);
        if (ev[1] != 0) begin
            check(r_out == er[1], et[1], r_out, er[1]);
            check(g_out == eg[1], et[1], g_out, eg[1]);
            check(b_out == eb[1], et[1], b_out, eb[1]);
        end
        ev[1] = ev[0]; eh[1] = eh[0]; evs[1] = evs[0];
        er[1] = er[0]; eg[1] = eg[0]; eb[1] = eb[0]; et[1] = et[0];

        pix_valid = v; h_pos = POS_W'(x); v_pos = POS_W'(y); frame_end = fe;
        hsync_in = v && (x == 0); vsync_in = v && (x == 0) && (y == 0);
        luma_in = 8'(lu); r_in = 8'(r); g_in = 8'(g); b_in = 8'(b);

        off = 0;
        if (m_peak > black_clamp) off = m_peak - black_clamp;
        if (off > stretch_cap) off = stretch_cap;
        corr = (stretch_en && lu < TH) ? (off * (TH - lu)) / TH : 0;
        ev[0] = v; eh[0] = hsync_in; evs[0] = vsync_in;
        er[0] = exp_chan(r, corr, black_clamp);
        eg[0] = exp_chan(g, corr, black_clamp);
        eb[0] = exp_chan(b, corr, black_clamp);
        et[0] = !stretch_en ? "R1" : (lu >= TH ? "R5" : (off == 0 ? "R4" : "R6"));

        inwin = v && x >= win_left && x <= win_right && y >= win_top && y <= win_bottom;
        if (fe) begin
            m_peak = (inwin && lu < m_run) ? lu : m_run;
            m_run  = 255;
        end else if (inwin && lu < m_run) begin
            m_run = lu;
        end
    endtask

    task automatic run_frame(input int fr, input int border, input int base,
                             input bit force_last, input int last_val, input string req);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                int lu;
                bit last;
                bit in_w;
                last = (x == W-1) && (y == H-1);
                in_w = x >= win_left && x <= win_right && y >= win_top && y <= win_bottom;
                lu = in_w ? base + ((x*37 + y*53 + fr*29) % (256 - base)) : border;
                if (last && force_last) lu = last_val;
                step(1'b1, x, y, last, lu, (lu + x*7) % 256, lu, (lu*3 + y*11) % 256);
            end
            // Blanking cycle: dark luma inside the window with valid low (R2)
            if (y != H-1) step(1'b0, 5, 3, 1'b0, 0, 0, 0, 0);
        end
        step(1'b0, 0, 0, 1'b0, 0, 0, 0, 0);
        check(dark_level == 8'(m_peak), req, dark_level, m_peak);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            ev[i] = 0; eh[i] = 0; evs[i] = 0; er[i] = 0; eg[i] = 0; eb[i] = 0; et[i] = "R7";
        end
        pix_valid = 1'b1; luma_in = 8'd9; r_in = 8'd200; frame_end = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(r_out == 0 && g_out == 0 && b_out == 0, "R8", r_out, 0);
        check(valid_out == 0 && hsync_out == 0 && vsync_out == 0, "R8", valid_out, 0);
        check(dark_level == 0, "R8", dark_level, 0);
        pix_valid = 1'b0; frame_end = 1'b0; luma_in = '0; r_in = '0;
        rst = 1'b0;
        @(negedge clk);
        check(dark_level == 0 && valid_out == 0, "R8", dark_level, 0);

        stretch_en = 1'b1; black_clamp = 8'd16; stretch_cap = 8'd40;
        win_left = 10'd2; win_right = 10'd13; win_top = 10'd1; win_bottom = 10'd6;
        // Black borders outside the window must not pull the level down (R2)
        run_frame(0, 0, 60, 1'b0, 0, "R2");
        run_frame(1, 3, 20, 1'b0, 0, "R2");
        // A higher minimum shows the running minimum restarted (R3)
        run_frame(2, 1, 100, 1'b0, 0, "R3");
        // Level below clamp gives zero offset (R4)
        black_clamp = 8'd120;
        run_frame(3, 2, 30, 1'b0, 0, "R4");
        black_clamp = 8'd16;
        // Disabled: pure pass-through (R1)
        stretch_en = 1'b0;
        run_frame(4, 0, 90, 1'b0, 0, "R1");
        stretch_en = 1'b1;
        // Full window, minimum on the frame-end pixel itself (R3), uncapped
        stretch_cap = 8'd255;
        win_left = 10'd0; win_right = 10'(W-1); win_top = 10'd0; win_bottom = 10'(H-1);
        run_frame(5, 0, 70, 1'b1, 40, "R3");
        // Offset 24 now applied with taper (R5, R6)
        run_frame(6, 0, 0, 1'b0, 0, "R3");
        stretch_cap = 8'd10;
        run_frame(7, 0, 35, 1'b0, 0, "R4");
        step(1'b0, 0, 0, 1'b0, 0, 0, 0, 0);
        step(1'b0, 0, 0, 1'b0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule